// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator with Dead-Time

This block drives the six gate signals of a three-phase bridge: a top and a bottom switch for each of phases A, B and C. Every PWM period of `T` ticks shares one center instant. Each phase places its edges symmetrically around that center from a requested high-time. Dead-time separates the top from the bottom of the same phase. High-times that would give pulses narrower than a minimum width are clamped. The high-times themselves are computed elsewhere and arrive as inputs.

The host prepares a new period, reload prescaler and three high-times, then raises a load-ready flag with a one-cycle pulse. At each reload point the block takes the new set only if the flag is up. A reload point is the end of every prescaler-th period. The block then clears the flag and emits a one-cycle reload interrupt.

An init pulse starts a quiet boot interval, so the bootstrap supplies can charge. During the first run the phases stay at half duty. A falling edge on the fault pin shuts every gate off at once and keeps them off until the next init. A stop pulse simply returns the block to idle.

Top module: `pwm3_center`

## Requirements
- R1: After reset all six gate outputs are low, `ld_ok` is 0 and `rld_irq` is 0. They stay that way until `init` is pulsed.
- R2: After the clock edge that samples `init`, all gates stay low for `BOOT_TICKS` further edges (default 32000, that is 1.6 ms at 20 MHz). The PWM then starts with its period counter at 0.
- R3: When the PWM starts, the period and prescaler are taken from the inputs. Every phase uses a high-time of floor(T/2) until the first accepted reload.
- R4: Let c = floor(T/2) and k be the period counter (0..T-1). For a phase with high-time h, the top gate is high exactly when c - th <= k < c + th. Here th = floor((h-DT)/2), and th = 0 when h <= DT.
- R5: The bottom gate of that phase is low exactly when c - bh <= k < c + bh, with bh = floor((h+DT)/2). As exceptions, h = 0 gives top low and bottom high for the whole period, and h = T gives top high and bottom low for the whole period.
- R6: A reload point is the last tick of every P-th period, where P is the active prescaler and P = 0 counts as 1. If `ld_ok` is 1 there, the new T, P and high-times apply from counter value 0 of the next period.
- R7: A one-cycle `ld_set` pulse sets `ld_ok`. An accepted reload clears it, and clearing wins over a simultaneous set. `rld_irq` is high for exactly the one cycle after an accepted reload.
- R8: Each loaded high-time h is first limited to T. If the result is below MPW it becomes 0, and if it is above T-MPW it becomes T.
- R9: The top and bottom gates of the same phase are never high in the same cycle.
- R10: The fault pin is synchronized by two flip-flops. In the cycle after the second stage sees a high-to-low change, all gates are low, and they stay low even if the pin returns high. Only a new `init` restarts the block.
- R11: `fault_lvl` reports the pin level (1 high, 0 low) with a two-cycle delay.
- R12: A `stop` pulse returns the block to idle, and all gates are low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init | input | 1 | One-cycle start pulse, begins the boot interval |
| stop | input | 1 | One-cycle pulse returning to idle |
| period | input | W | Requested PWM period T in ticks (>= 2) |
| presc | input | W | Requested periods per reload (0 means 1) |
| dead | input | W | Dead-time in ticks, held constant while running |
| mpw | input | W | Minimum pulse width in ticks, held constant while running |
| ht_a | input | W | Requested high-time of phase A |
| ht_b | input | W | Requested high-time of phase B |
| ht_c | input | W | Requested high-time of phase C |
| ld_set | input | 1 | Host pulse marking a new value set as ready |
| ld_ok | output | 1 | Load-ready flag, cleared by an accepted reload |
| rld_irq | output | 1 | One-cycle reload interrupt |
| fault_n | input | 1 | Fault pin, active on its falling edge |
| fault_lvl | output | 1 | Synchronized fault pin level |
| a_top | output | 1 | Phase A top gate |
| a_bot | output | 1 | Phase A bottom gate |
| b_top | output | 1 | Phase B top gate |
| b_bot | output | 1 | Phase B bottom gate |
| c_top | output | 1 | Phase C top gate |
| c_bot | output | 1 | Phase C bottom gate |

## Verification
The hardest case to reach is a handshake that meets a reload point in a chosen cycle. A reload point comes only after the boot wait plus P full periods, so its timing depends on T and P at once. The bench shortens the boot interval through its parameter and keeps prescalers small, including 0. It fires `ld_set` and changes the high-time inputs at random cycles. Over thousands of periods this lands flag-set pulses on reload edges, just before them and just after them. A cycle-level reference model in the bench predicts which value set each period must show.

// File: rtl/pwm3_center.sv
`timescale 1ns/1ps
module pwm3_center #(
  parameter int W = 16,
  parameter int BOOT_TICKS = 32000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         stop,
  input  logic [W-1:0] period,
  input  logic [W-1:0] presc,
  input  logic [W-1:0] dead,
  input  logic [W-1:0] mpw,
  input  logic [W-1:0] ht_a,
  input  logic [W-1:0] ht_b,
  input  logic [W-1:0] ht_c,
  input  logic         ld_set,
  output logic         ld_ok,
  output logic         rld_irq,
  input  logic         fault_n,
  output logic         fault_lvl,
  output logic         a_top,
  output logic         a_bot,
  output logic         b_top,
  output logic         b_bot,
  output logic         c_top,
  output logic         c_bot
);
  localparam int BW = $clog2(BOOT_TICKS + 1);
  localparam logic [BW-1:0] BLAST = BW'(BOOT_TICKS - 1);
  localparam int NPH = 3;

  typedef enum logic [1:0] {S_IDLE, S_BOOT, S_RUN, S_FAULT} st_t;

  function automatic logic [W-1:0] clamp_ht(input logic [W-1:0] h, input logic [W-1:0] t,
                                            input logic [W-1:0] m);
    logic [W-1:0] x;
    x = (h > t) ? t : h;
    if (x < m) return '0;
    else if (x > t - m) return t;
    else return x;
  endfunction

  function automatic logic [W-1:0] half_top(input logic [W-1:0] h, input logic [W-1:0] dt);
    return (h > dt) ? (h - dt) >> 1 : '0;
  endfunction

  function automatic logic [W-1:0] half_bot(input logic [W-1:0] h, input logic [W-1:0] dt);
    logic [W:0] s;
    s = {1'b0, h} + {1'b0, dt};
    return s[W:1];
  endfunction

  st_t st;
  logic [W-1:0] cnt, pc, t_q, p_q;
  logic [BW-1:0] bcnt;
  logic [W-1:0] th_q [NPH];
  logic [W-1:0] bh_q [NPH];
  logic [NPH-1:0] full_q, zero_q;
  logic s1, s2, s3;

  wire fall = s3 & ~s2;
  wire run_ok = (st == S_RUN) && !fall;
  wire [W-1:0] p_eff = (p_q == '0) ? W'(1) : p_q;
  wire last_tick = cnt == t_q - W'(1);
  wire rld_pt = run_ok && last_tick && (pc == p_eff - W'(1));
  wire take = rld_pt && ld_ok;
  wire boot_done = (st == S_BOOT) && (bcnt == BLAST);
  wire load = boot_done || take;
  wire [W:0] c_ext = {2'b0, t_q[W-1:1]};
  wire [W:0] k_ext = {1'b0, cnt};

  logic [W-1:0] src_ht [NPH];
  logic [W-1:0] hcl [NPH];
  always_comb begin
    src_ht[0] = boot_done ? (period >> 1) : ht_a;
    src_ht[1] = boot_done ? (period >> 1) : ht_b;
    src_ht[2] = boot_done ? (period >> 1) : ht_c;
    for (int i = 0; i < NPH; i++) hcl[i] = clamp_ht(src_ht[i], period, mpw);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= fault_n;
      s2 <= s1;
      s3 <= s2;
    end
  end
  assign fault_lvl = s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      pc   <= '0;
      bcnt <= '0;
      t_q  <= '0;
      p_q  <= '0;
    end else begin
      if (fall) st <= S_FAULT;
      else if (init) begin
        st   <= S_BOOT;
        bcnt <= '0;
      end else if (stop) st <= S_IDLE;
      else begin
        case (st)
          S_BOOT: begin
            if (boot_done) begin
              st  <= S_RUN;
              cnt <= '0;
              pc  <= '0;
            end else bcnt <= bcnt + BW'(1);
          end
          S_RUN: begin
            if (last_tick) begin
              cnt <= '0;
              pc  <= (pc == p_eff - W'(1)) ? '0 : pc + W'(1);
            end else cnt <= cnt + W'(1);
          end
          default: ;
        endcase
      end
      if (load) begin
        t_q <= period;
        p_q <= presc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      zero_q <= '0;
      for (int i = 0; i < NPH; i++) begin
        th_q[i] <= '0;
        bh_q[i] <= '0;
      end
    end else if (load) begin
      for (int i = 0; i < NPH; i++) begin
        th_q[i]   <= half_top(hcl[i], dead);
        bh_q[i]   <= half_bot(hcl[i], dead);
        full_q[i] <= hcl[i] == period;
        zero_q[i] <= hcl[i] == '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_ok   <= 1'b0;
      rld_irq <= 1'b0;
    end else begin
      rld_irq <= take;
      if (take) ld_ok <= 1'b0;
      else if (ld_set) ld_ok <= 1'b1;
    end
  end

  logic [NPH-1:0] top_w, bot_w;
  for (genvar g = 0; g < NPH; g++) begin : g_ph
    wire [W:0] th_e = {1'b0, th_q[g]};
    wire [W:0] bh_e = {1'b0, bh_q[g]};
    wire in_top = (k_ext + th_e >= c_ext) && (k_ext < c_ext + th_e);
    wire in_bot = (k_ext + bh_e >= c_ext) && (k_ext < c_ext + bh_e);
    wire top_raw = full_q[g] | (!zero_q[g] & in_top);
    wire bot_raw = zero_q[g] | (!full_q[g] & !in_bot);
    assign top_w[g] = run_ok & top_raw;
    assign bot_w[g] = run_ok & bot_raw;
  end

  assign a_top = top_w[0];
  assign a_bot = bot_w[0];
  assign b_top = top_w[1];
  assign b_bot = bot_w[1];
  assign c_top = top_w[2];
  assign c_bot = bot_w[2];

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_top && a_bot) && !(b_top && b_bot) && !(c_top && c_bot));

  p_irq_follows_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ld_ok) |-> rld_irq);

  p_irq_flag_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rld_irq |-> !ld_ok);

  p_fault_cut_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_lvl) |-> !(a_top || a_bot || b_top || b_bot || c_top || c_bot));

  p_fault_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FAULT && !init && !stop) |=> st == S_FAULT);

  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && t_q != '0) |-> cnt < t_q);
endmodule

// File: tb/tb_pwm3_center.sv
`timescale 1ns/1ps
module tb_pwm3_center;
  localparam int W = 16;
  localparam int BT = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0, stop = 1'b0, ld_set = 1'b0, fault_n = 1'b1;
  logic [W-1:0] period = 16'd40, presc = 16'd1, dead = 16'd0, mpw = 16'd0;
  logic [W-1:0] ht_a = '0, ht_b = '0, ht_c = '0;
  logic ld_ok, rld_irq, fault_lvl, a_top, a_bot, b_top, b_bot, c_top, c_bot;

  pwm3_center #(.W(W), .BOOT_TICKS(BT)) dut (
    .clk(clk), .rst_n(rst_n), .init(init), .stop(stop), .period(period), .presc(presc),
    .dead(dead), .mpw(mpw), .ht_a(ht_a), .ht_b(ht_b), .ht_c(ht_c), .ld_set(ld_set),
    .ld_ok(ld_ok), .rld_irq(rld_irq), .fault_n(fault_n), .fault_lvl(fault_lvl),
    .a_top(a_top), .a_bot(a_bot), .b_top(b_top), .b_bot(b_bot), .c_top(c_top), .c_bot(c_bot));

  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 0;
  string cur_tag = "R1";

  int m_st = 0, m_b = 0, m_cnt = 0, m_pc = 0, m_T = 0, m_P = 0;
  int m_h [3];
  int m_ldok = 0, m_irq = 0, m_s1 = 1, m_s2 = 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int clampm(input int h, input int t, input int m);
    int x;
    x = (h > t) ? t : h;
    if (x < m) return 0;
    if (x > t - m) return t;
    return x;
  endfunction

  function automatic logic [1:0] exp_pair(input int k, input int t, input int h, input int dt);
    int c, tw, bw, d;
    if (h == 0) return 2'b01;
    if (h == t) return 2'b10;
    c  = t / 2;
    tw = (h > dt) ? (h - dt) / 2 : 0;
    bw = (h + dt) / 2;
    d  = k - c;
    return {(d >= -tw) && (d < tw), !((d >= -bw) && (d < bw))};
  endfunction

  task automatic m_step();
    int cons, nst, pe, old2;
    cons = 0;
    nst = m_st;
    if (m_st == 1) begin
      if (m_b == BT - 1) begin
        nst = 2; m_cnt = 0; m_pc = 0; m_T = int'(period); m_P = int'(presc);
        for (int i = 0; i < 3; i++) m_h[i] = clampm(int'(period) / 2, int'(period), int'(mpw));
      end else m_b++;
    end else if (m_st == 2) begin
      pe = (m_P == 0) ? 1 : m_P;
      if (m_cnt == m_T - 1) begin
        m_cnt = 0;
        if (m_pc == pe - 1) begin
          m_pc = 0;
          if (m_ldok != 0) begin
            cons = 1; m_T = int'(period); m_P = int'(presc);
            m_h[0] = clampm(int'(ht_a), m_T, int'(mpw));
            m_h[1] = clampm(int'(ht_b), m_T, int'(mpw));
            m_h[2] = clampm(int'(ht_c), m_T, int'(mpw));
          end
        end else m_pc++;
      end else m_cnt++;
    end
    if (init) begin nst = 1; m_b = 0; end
    else if (stop) nst = 0;
    m_st = nst;
    m_ldok = cons ? 0 : (ld_set ? 1 : m_ldok);
    m_irq = cons;
    old2 = m_s2; m_s2 = m_s1; m_s1 = int'(fault_n);
    if (old2 == 1 && m_s2 == 0) m_st = 0;
  endtask

  task automatic compare();
    logic [5:0] got, ex;
    logic [1:0] p;
    got = {a_top, a_bot, b_top, b_bot, c_top, c_bot};
    ex = '0;
    if (m_st == 2) begin
      for (int i = 0; i < 3; i++) begin
        p = exp_pair(m_cnt, m_T, m_h[i], int'(dead));
        ex[5 - 2*i -: 2] = p;
      end
    end
    chk(got == ex, cur_tag, int'(got), int'(ex));
    chk(!(a_top && a_bot) && !(b_top && b_bot) && !(c_top && c_bot), "R9", int'(got), 0);
    chk(ld_ok == m_ldok[0], "R7 ld_ok", int'(ld_ok), m_ldok);
    chk(rld_irq == m_irq[0], "R7 irq", int'(rld_irq), m_irq);
    chk(fault_lvl == m_s2[0], "R11", int'(fault_lvl), m_s2);
  endtask

  task automatic tick();
    @(posedge clk);
    m_step();
    @(negedge clk);
    compare();
  endtask

  task automatic pulse_init();
    init = 1'b1; tick(); init = 1'b0;
  endtask

  task automatic pulse_ld();
    ld_set = 1'b1; tick(); ld_set = 1'b0;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20517));
    repeat (3) @(negedge clk);
    // R1: reset state
    cur_tag = "R1";
    compare();
    rst_n = 1'b1;
    repeat (5) tick();

    // R2 and R3: boot quiet, then half duty
    dead = 16'd4; mpw = 16'd6; period = 16'd40; presc = 16'd1;
    cur_tag = "R2";
    pulse_init();
    repeat (BT) tick();
    cur_tag = "R3";
    repeat (90) tick();

    // R5: 0% and 100% and a middle value
    cur_tag = "R5";
    ht_a = 16'd0; ht_b = 16'd40; ht_c = 16'd21;
    pulse_ld();
    repeat (100) tick();

    // R8: clamp boundaries, with R6 prescaler 0 and a period change
    cur_tag = "R8";
    ht_a = 16'd5; ht_b = 16'd25; ht_c = 16'd200; period = 16'd30; presc = 16'd0;
    pulse_ld();
    repeat (80) tick();
    ht_a = 16'd6; ht_b = 16'd24; ht_c = 16'd29;
    pulse_ld();
    repeat (80) tick();

    // R6: prescaler 3, reload only every third period
    cur_tag = "R6";
    presc = 16'd3; ht_a = 16'd10;
    pulse_ld();
    repeat (70) tick();
    ht_a = 16'd20; ht_b = 16'd12;
    pulse_ld();
    repeat (300) tick();

    // R12: stop
    cur_tag = "R12";
    stop = 1'b1; tick(); stop = 1'b0;
    repeat (40) tick();

    // R4 and R7: randomized runs
    for (int run = 0; run < 8; run++) begin
      cur_tag = "R4";
      dead = 16'($urandom_range(0, 8));
      mpw = 16'($urandom_range(0, 10));
      period = 16'($urandom_range(30, 120));
      presc = 16'($urandom_range(0, 3));
      pulse_init();
      for (int cyc = 0; cyc < 2500; cyc++) begin
        if ($urandom_range(0, 20) == 0) ht_a = 16'($urandom_range(0, int'(period) + 10));
        if ($urandom_range(0, 20) == 0) ht_b = 16'($urandom_range(0, int'(period) + 10));
        if ($urandom_range(0, 20) == 0) ht_c = 16'($urandom_range(0, int'(period) + 10));
        if ($urandom_range(0, 300) == 0) period = 16'($urandom_range(30, 120));
        if ($urandom_range(0, 300) == 0) presc = 16'($urandom_range(0, 3));
        ld_set = ($urandom_range(0, 40) == 0);
        tick();
        ld_set = 1'b0;
      end
    end

    // R10: fault shutdown, latched while the pin recovers, cleared by init
    cur_tag = "R10";
    ld_set = 1'b0;
    repeat (3) tick();
    fault_n = 1'b0;
    repeat (50) tick();
    fault_n = 1'b1;
    repeat (120) tick();
    cur_tag = "R3";
    period = 16'd40; presc = 16'd1;
    pulse_init();
    repeat (BT + 100) tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule